// File: doc/BRIEF.md
# Staged Reset Release Sequencer with Shared Retry Budget

This block brings a system out of reset in three stages. A start pulse first holds both reset lines low for a fixed number of cycles. The block then releases the graphics reset and waits for that device to report that its reset has completed. Next it waits for the PCIe link status to show L0. Finally it releases the CPU reset and waits for a one-cycle software handshake. When the handshake arrives, the system is declared up.

Each of the three waits has its own timeout. A timeout produces a one-cycle log pulse that names the stage that failed. One attempt counter is shared by all three stages. It is cleared only when a new sequence is launched from idle; a retry never clears it. While attempts remain, a timeout returns the block to the reset-hold step, and the release sequence starts over. The timeout that uses up the last attempt instead sends the block to a terminal state. That state carries an error code for the stage that failed. The code is held until an external clear returns the block to idle.

Top module: `rst_release_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, both reset lines are low, `up_o` is low, every log output is low and `err_code_o` is 0.
- R2: A `start_i` pulse sampled in idle holds both reset lines low for exactly `HOLD_CYC` cycles, after which `gfx_rst_n_o` goes high and `cpu_rst_n_o` stays low. `start_i` has no effect in any state other than idle.
- R3: In the graphics wait, `gfx_done_i` moves the block to the link wait. In the link wait, `link_l0_i` raises `cpu_rst_n_o`. In the handshake wait, `hs_pulse_i` raises `up_o`. `cpu_rst_n_o` is never high while `gfx_rst_n_o` is low.
- R4: If `gfx_done_i` is not seen within `GFX_TMO` cycles of the graphics wait, `log_gfx_o` pulses and both reset lines go low. While attempts remain, the block re-runs the hold step.
- R5: If `link_l0_i` is not seen within `LINK_TMO` cycles of the link wait, `log_link_o` pulses and the block retries or stops in the same way as R4.
- R6: If `hs_pulse_i` is not seen within `HS_TMO` cycles of the handshake wait, `log_cpu_o` pulses and the block retries or stops in the same way as R4.
- R7: Timeouts from any mix of stages count against one budget. The `MAX_TRIES`-th timeout since launch enters the terminal state, with both reset lines low and `err_code_o` set to 1 for graphics, 2 for link or 3 for handshake.
- R8: The terminal code holds, and `start_i` is ignored, until `clear_i` is sampled. The code then reads 0 on the next cycle. `clear_i` sampled while up also returns the block to idle. A later launch starts with a full attempt budget.
- R9: An awaited event sampled in the final cycle of its window counts as success. The same event sampled one cycle later is too late.
- R10: Each log output is high for exactly one cycle per timeout, and no two log outputs are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, acted on only in idle |
| clear_i | input | 1 | Leave terminal or up state and return to idle |
| gfx_done_i | input | 1 | Graphics device reports reset complete |
| link_l0_i | input | 1 | PCIe link status shows L0 |
| hs_pulse_i | input | 1 | Software handshake pulse |
| gfx_rst_n_o | output | 1 | Graphics reset, active low |
| cpu_rst_n_o | output | 1 | CPU reset, active low |
| up_o | output | 1 | Sequence completed |
| log_gfx_o | output | 1 | One-cycle pulse on graphics timeout |
| log_link_o | output | 1 | One-cycle pulse on link timeout |
| log_cpu_o | output | 1 | One-cycle pulse on handshake timeout |
| err_code_o | output | 2 | Terminal code: 0 none, 1 graphics, 2 link, 3 handshake |

## Verification
Within one wait state, the awaited event and the expiry of its window can fall in the same cycle. The bench provokes this by driving `gfx_done_i` and `hs_pulse_i` so that they are sampled on exactly the last cycle of their windows. It expects the stage to advance with no log pulse. It then drives `link_l0_i` one cycle late and expects a link log pulse and a return to the hold step.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WGFX,
    ST_WLINK,
    ST_WHS,
    ST_UP,
    ST_FAIL
  } rrs_state_e;

  localparam logic [1:0] CODE_NONE = 2'd0;
  localparam logic [1:0] CODE_GFX  = 2'd1;
  localparam logic [1:0] CODE_LINK = 2'd2;
  localparam logic [1:0] CODE_HS   = 2'd3;
endpackage

// File: rtl/rrs_timer.sv
module rrs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != {W{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rrs_attempts.sv
module rrs_attempts #(
  parameter int MAX_TRIES = 3,
  parameter int CW        = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          last
);
  // last: the next timeout spends the final attempt
  assign last = (cnt == CW'(MAX_TRIES - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != CW'(MAX_TRIES))) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
  import rrs_pkg::*;
#(
  parameter int HOLD_CYC  = 16,
  parameter int GFX_TMO   = 1000,
  parameter int LINK_TMO  = 2000,
  parameter int HS_TMO    = 4000,
  parameter int MAX_TRIES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       clear_i,
  input  logic       gfx_done_i,
  input  logic       link_l0_i,
  input  logic       hs_pulse_i,
  output logic       gfx_rst_n_o,
  output logic       cpu_rst_n_o,
  output logic       up_o,
  output logic       log_gfx_o,
  output logic       log_link_o,
  output logic       log_cpu_o,
  output logic [1:0] err_code_o
);
  localparam int LIM_A   = (HOLD_CYC > GFX_TMO) ? HOLD_CYC : GFX_TMO;
  localparam int LIM_B   = (LINK_TMO > HS_TMO) ? LINK_TMO : HS_TMO;
  localparam int LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int TW      = $clog2(LIM_MAX + 1);
  localparam int CW      = $clog2(MAX_TRIES + 1);

  rrs_state_e    state_q, state_d;
  logic [TW-1:0] tcnt;
  logic [CW-1:0] att_cnt;
  logic          att_last;
  logic          att_clr;
  logic          waiting;
  logic          evt;
  logic          hit;
  logic          tmo;
  int            lim;
  logic [1:0]    stage_code;

  rrs_timer #(.W(TW)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (state_d != state_q),
    .cnt (tcnt)
  );

  rrs_attempts #(.MAX_TRIES(MAX_TRIES), .CW(CW)) u_att (
    .clk  (clk),
    .rst  (rst),
    .clr  (att_clr),
    .inc  (tmo),
    .cnt  (att_cnt),
    .last (att_last)
  );

  // per-state window length, awaited event and error code
  always_comb begin
    lim        = HOLD_CYC;
    evt        = 1'b0;
    waiting    = 1'b0;
    stage_code = CODE_NONE;
    case (state_q)
      ST_WGFX:  begin lim = GFX_TMO;  evt = gfx_done_i; waiting = 1'b1; stage_code = CODE_GFX;  end
      ST_WLINK: begin lim = LINK_TMO; evt = link_l0_i;  waiting = 1'b1; stage_code = CODE_LINK; end
      ST_WHS:   begin lim = HS_TMO;   evt = hs_pulse_i; waiting = 1'b1; stage_code = CODE_HS;   end
      default:  ;
    endcase
  end

  assign hit     = (tcnt == TW'(lim - 1));
  assign tmo     = waiting && !evt && hit;   // event on the last cycle wins
  assign att_clr = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_HOLD;
      ST_HOLD:  if (hit) state_d = ST_WGFX;
      ST_WGFX:  if (evt) state_d = ST_WLINK;
                else if (tmo) state_d = att_last ? ST_FAIL : ST_HOLD;
      ST_WLINK: if (evt) state_d = ST_WHS;
                else if (tmo) state_d = att_last ? ST_FAIL : ST_HOLD;
      ST_WHS:   if (evt) state_d = ST_UP;
                else if (tmo) state_d = att_last ? ST_FAIL : ST_HOLD;
      ST_UP:    if (clear_i) state_d = ST_IDLE;
      ST_FAIL:  if (clear_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      gfx_rst_n_o <= 1'b0;
      cpu_rst_n_o <= 1'b0;
      up_o        <= 1'b0;
      log_gfx_o   <= 1'b0;
      log_link_o  <= 1'b0;
      log_cpu_o   <= 1'b0;
      err_code_o  <= CODE_NONE;
    end else begin
      state_q     <= state_d;
      gfx_rst_n_o <= state_d inside {ST_WGFX, ST_WLINK, ST_WHS, ST_UP};
      cpu_rst_n_o <= state_d inside {ST_WHS, ST_UP};
      up_o        <= (state_d == ST_UP);
      log_gfx_o   <= tmo && (state_q == ST_WGFX);
      log_link_o  <= tmo && (state_q == ST_WLINK);
      log_cpu_o   <= tmo && (state_q == ST_WHS);
      if (state_q == ST_FAIL && clear_i) begin
        err_code_o <= CODE_NONE;
      end else if (tmo && att_last) begin
        err_code_o <= stage_code;
      end
    end
  end
endmodule

// File: rtl/rrs_check.sv
module rrs_check #(
  parameter int MAX_TRIES = 3,
  parameter int CW        = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          clear_i,
  input logic          gfx_rst_n_o,
  input logic          cpu_rst_n_o,
  input logic          up_o,
  input logic          log_gfx_o,
  input logic          log_link_o,
  input logic          log_cpu_o,
  input logic [1:0]    err_code_o,
  input logic [CW-1:0] att_cnt
);
  p_cpu_after_gfx_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_rst_n_o |-> gfx_rst_n_o);

  p_up_released_r3: assert property (@(posedge clk) disable iff (rst)
    up_o |-> (cpu_rst_n_o && gfx_rst_n_o));

  p_gfx_log_reset_r4: assert property (@(posedge clk) disable iff (rst)
    log_gfx_o |-> !gfx_rst_n_o);

  p_link_log_reset_r5: assert property (@(posedge clk) disable iff (rst)
    log_link_o |-> !gfx_rst_n_o);

  p_cpu_log_reset_r6: assert property (@(posedge clk) disable iff (rst)
    log_cpu_o |-> (!gfx_rst_n_o && !cpu_rst_n_o));

  p_fail_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (err_code_o != 2'd0) |-> (!gfx_rst_n_o && !cpu_rst_n_o && !up_o));

  p_budget_bound_r7: assert property (@(posedge clk) disable iff (rst)
    att_cnt <= CW'(MAX_TRIES));

  p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ((err_code_o != 2'd0) && !clear_i) |=> $stable(err_code_o));

  p_log_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({log_gfx_o, log_link_o, log_cpu_o}));

  p_log_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (log_gfx_o || log_link_o || log_cpu_o) |=> !(log_gfx_o || log_link_o || log_cpu_o));
endmodule

bind rst_release_seq rrs_check #(.MAX_TRIES(MAX_TRIES), .CW(CW)) u_rrs_check (
  .clk         (clk),
  .rst         (rst),
  .clear_i     (clear_i),
  .gfx_rst_n_o (gfx_rst_n_o),
  .cpu_rst_n_o (cpu_rst_n_o),
  .up_o        (up_o),
  .log_gfx_o   (log_gfx_o),
  .log_link_o  (log_link_o),
  .log_cpu_o   (log_cpu_o),
  .err_code_o  (err_code_o),
  .att_cnt     (att_cnt)
);

// File: tb/tb_rst_release_seq.sv
`timescale 1ns/1ps
module tb_rst_release_seq;
  localparam int HOLD  = 4;
  localparam int GTMO  = 8;
  localparam int LTMO  = 10;
  localparam int HTMO  = 12;
  localparam int MAXT  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, clear_i = 1'b0;
  logic gfx_done_i = 1'b0, link_l0_i = 1'b0, hs_pulse_i = 1'b0;
  logic gfx_rst_n_o, cpu_rst_n_o, up_o;
  logic log_gfx_o, log_link_o, log_cpu_o;
  logic [1:0] err_code_o;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rst_release_seq #(
    .HOLD_CYC(HOLD), .GFX_TMO(GTMO), .LINK_TMO(LTMO), .HS_TMO(HTMO), .MAX_TRIES(MAXT)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .clear_i(clear_i),
    .gfx_done_i(gfx_done_i), .link_l0_i(link_l0_i), .hs_pulse_i(hs_pulse_i),
    .gfx_rst_n_o(gfx_rst_n_o), .cpu_rst_n_o(cpu_rst_n_o), .up_o(up_o),
    .log_gfx_o(log_gfx_o), .log_link_o(log_link_o), .log_cpu_o(log_cpu_o),
    .err_code_o(err_code_o)
  );

  function automatic int logs();
    return {29'd0, log_gfx_o, log_link_o, log_cpu_o};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // positioned right after entering the hold step
  task automatic hold_to_gfx(input string req);
    for (int i = 0; i < HOLD - 1; i++) begin
      step(1);
      chk(req, {gfx_rst_n_o, cpu_rst_n_o}, 0);
      chk("R10 pulse width", logs(), 0);
    end
    step(1);
    chk(req, {gfx_rst_n_o, cpu_rst_n_o}, 2);
  endtask

  task automatic launch();
    start_i = 1'b1; step(1); start_i = 1'b0;
    chk("R2 hold entry", {gfx_rst_n_o, cpu_rst_n_o}, 0);
    hold_to_gfx("R2 hold length");
  endtask

  task automatic gfx_ok();
    gfx_done_i = 1'b1; step(1); gfx_done_i = 1'b0;
    chk("R3 link wait", {gfx_rst_n_o, cpu_rst_n_o}, 2);
  endtask

  task automatic link_ok();
    link_l0_i = 1'b1; step(1); link_l0_i = 1'b0;
    chk("R3 cpu released", cpu_rst_n_o, 1);
  endtask

  task automatic hs_ok();
    hs_pulse_i = 1'b1; step(1); hs_pulse_i = 1'b0;
    chk("R3 up", up_o, 1);
  endtask

  // log pattern: 4 gfx, 2 link, 1 cpu
  task automatic expire(input int lim, input int pat, input string req);
    step(lim - 1);
    chk(req, logs(), 0);
    step(1);
    chk(req, logs(), pat);
    chk(req, {gfx_rst_n_o, cpu_rst_n_o}, 0);
  endtask

  task automatic do_clear();
    clear_i = 1'b1; step(1); clear_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(3);
    chk("R1 in reset", {gfx_rst_n_o, cpu_rst_n_o, up_o}, 0);
    rst = 1'b0; step(1);
    chk("R1 after reset", {gfx_rst_n_o, cpu_rst_n_o, up_o}, 0);
    chk("R1 logs", logs(), 0);
    chk("R1 code", err_code_o, 0);
  endtask

  task automatic t_boot();
    start_i = 1'b1; step(1); start_i = 1'b0;
    step(1);
    start_i = 1'b1; step(1); start_i = 1'b0;   // ignored mid-hold
    step(1);
    chk("R2 start ignored in hold", gfx_rst_n_o, 0);
    step(1);
    chk("R2 start ignored in hold", gfx_rst_n_o, 1);
    gfx_ok();
    link_ok();
    hs_ok();
    start_i = 1'b1; step(1); start_i = 1'b0;
    chk("R2 start ignored when up", {gfx_rst_n_o, cpu_rst_n_o, up_o}, 7);
    do_clear();
    chk("R8 clear from up", {gfx_rst_n_o, cpu_rst_n_o, up_o}, 0);
  endtask

  task automatic t_gfx_retry();
    launch();
    expire(GTMO, 4, "R4 gfx timeout");
    hold_to_gfx("R4 retry hold");
    gfx_ok(); link_ok(); hs_ok();
    chk("R4 no code after retry", err_code_o, 0);
    do_clear();
  endtask

  task automatic t_mixed();
    launch();
    expire(GTMO, 4, "R4 first");
    hold_to_gfx("R4 retry");
    gfx_ok();
    expire(LTMO, 2, "R5 link timeout");
    chk("R7 budget shared", err_code_o, 0);
    hold_to_gfx("R5 retry");
    gfx_ok(); link_ok();
    expire(HTMO, 1, "R6 hs timeout");
    chk("R7 third timeout terminal", err_code_o, 3);
    start_i = 1'b1; step(1); start_i = 1'b0;
    step(4);
    chk("R8 code held", err_code_o, 3);
    chk("R8 start ignored in fail", {gfx_rst_n_o, cpu_rst_n_o}, 0);
    do_clear();
    chk("R8 code cleared", err_code_o, 0);
    launch();
    expire(GTMO, 4, "R8 fresh budget");
    chk("R8 fresh budget", err_code_o, 0);
    hold_to_gfx("R8 fresh budget retry");
    gfx_ok(); link_ok(); hs_ok();
    do_clear();
  endtask

  task automatic t_term_gfx();
    launch();
    for (int k = 0; k < MAXT - 1; k++) begin
      expire(GTMO, 4, "R4 repeat");
      hold_to_gfx("R4 repeat");
    end
    expire(GTMO, 4, "R4 last");
    chk("R7 gfx code", err_code_o, 1);
    do_clear();
  endtask

  task automatic t_term_link();
    launch();
    for (int k = 0; k < MAXT - 1; k++) begin
      gfx_ok();
      expire(LTMO, 2, "R5 repeat");
      hold_to_gfx("R5 repeat");
    end
    gfx_ok();
    expire(LTMO, 2, "R5 last");
    chk("R7 link code", err_code_o, 2);
    do_clear();
    chk("R8 link code cleared", err_code_o, 0);
  endtask

  task automatic t_edge();
    launch();
    step(GTMO - 1);
    gfx_done_i = 1'b1; step(1); gfx_done_i = 1'b0;
    chk("R9 gfx last cycle", logs(), 0);
    chk("R9 gfx last cycle", {gfx_rst_n_o, cpu_rst_n_o}, 2);
    link_ok();
    step(HTMO - 1);
    hs_pulse_i = 1'b1; step(1); hs_pulse_i = 1'b0;
    chk("R9 hs last cycle", up_o, 1);
    chk("R9 hs last cycle", logs(), 0);
    do_clear();
    launch();
    gfx_ok();
    step(LTMO);
    chk("R9 link late", logs(), 2);
    link_l0_i = 1'b1; step(1); link_l0_i = 1'b0;
    chk("R9 late event no effect", {gfx_rst_n_o, cpu_rst_n_o}, 0);
    t_reset();
  endtask

  initial begin
    step(1);
    t_reset();
    t_boot();
    t_gfx_retry();
    t_mixed();
    t_term_gfx();
    t_term_link();
    t_edge();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule